// File: doc/BRIEF.md
# Serial Link Command Decoder with Cyclic Raw Transmit

This block sits behind the control interface of a serial link controller. Software writes one byte. Each set bit in that byte becomes a single-cycle control action for the rest of the controller. One action frees a receive buffer that software has already read. Another clears the receiver. A third starts a timer. One bit sets the ready/not-ready answer used for acknowledgements. The last kind of action manages a small byte queue on the transmit side.

In most modes the transmit queue is a plain FIFO. Bytes go in through a load stream and come out through a drain stream toward the framing logic. In the two extended transparent modes, a single combined command write freezes the queue and plays its contents out on a serial pin without end. Bits go out least significant first, with no flags, no checksum and no bit insertion, and the last bit of the block is followed at once by the first bit of the next pass. Only the transmitter-reset command ends the replay. That command also empties the queue.

Both byte streams use valid/ready handshakes. A byte moves on a clock edge where valid and ready are both high. The block withdraws `ld_ready` when the queue is full or replaying. It withdraws `dr_valid` when the queue is empty or replaying. A producer may hold valid high for as long as it likes, and the data must stay stable until the byte is taken. The mode, the bit-clock enable and all pulse and status pins are plain signals.

Top module: `scc_cmd_unit`

## Requirements
- R1: A write with bit 7 set, bit 6 set or bit 4 set produces a one-cycle high pulse on `rx_release`, `rx_reset` or `timer_start` respectively. The pulse appears in the cycle that follows the write edge. Bits that are clear produce no pulse.
- R2: `seq_clear` pulses together with `rx_reset` only when `mode` is 2'b00 (auto) at the write. In every other mode it stays low.
- R3: In auto mode every write loads bit 5 into `rnr_status` (1 = not ready, 0 = ready). Writes in any other mode leave `rnr_status` unchanged.
- R4: `ld_ready` is high exactly when the queue holds fewer than DEPTH bytes and no replay is running. The queue never holds more than DEPTH bytes.
- R5: Outside replay, `dr_data` presents the oldest byte while `dr_valid` is high, and bytes leave in the order they were loaded.
- R6: A replay starts only when all of the following hold at the write edge: the written value has bits 5, 3 and 1 set and bit 0 clear; `mode` is 2'b10 or 2'b11; the queue is not empty. `repeat_active` rises two edges after the write. Mode 2'b01 never starts a replay.
- R7: During replay `sdo` carries the queued bytes least significant bit first, oldest byte first. It advances one bit per clock edge with `bit_en` high, and it wraps from the last bit of the newest byte straight to the first bit of the oldest.
- R8: While `bit_en` is low, `sdo` holds its value.
- R9: A write with bit 0 set pulses `tx_reset`. One edge later the replay is stopped, the queue is empty and `sdo` is high. This command wins over every other bit in the same write, so 0x2B starts nothing.
- R10: In auto mode a write of 0x2A only updates `rnr_status`. It never starts a replay and never locks the queue.
- R11: After reset all pulses and `rnr_status` are low, `sdo` is high and the queue is empty. `sdo` is high whenever no replay runs.
- R12: While a replay runs, `ld_ready` and `dr_valid` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte |
| mode | input | 2 | 00 auto, 01 non-auto, 10/11 extended transparent |
| ld_valid | input | 1 | Load stream valid |
| ld_ready | output | 1 | Load stream ready |
| ld_data | input | WIDTH | Load stream byte |
| dr_valid | output | 1 | Drain stream valid |
| dr_ready | input | 1 | Drain stream ready |
| dr_data | output | WIDTH | Drain stream byte (oldest) |
| bit_en | input | 1 | Serial bit-clock enable |
| sdo | output | 1 | Serial data out, idle high |
| repeat_active | output | 1 | Replay running |
| rnr_status | output | 1 | 1 = receiver not ready |
| rx_release | output | 1 | Receive space release pulse |
| rx_reset | output | 1 | Receiver reset pulse |
| seq_clear | output | 1 | Sequence counter clear pulse |
| timer_start | output | 1 | Timer start pulse |
| tx_reset | output | 1 | Transmitter reset pulse |

## Verification
The hardest case to reach is the wrap seam when the queue is completely full. It also needs the read pointer to sit away from slot zero, so that the serial peek crosses the end of the storage array in the middle of a pass. The stimulus gets there in three steps. It first drains a few bytes through the drain stream to move the read pointer. It then fills all DEPTH slots and checks that `ld_ready` falls. Finally it starts a replay and scores one full pass plus the first byte of the next pass against a queue of expected bits. A second delicate point is a stall in the middle of a byte. There the bench drops `bit_en` with expected bits still queued, checks that `sdo` holds, and resumes scoring from the next bit.

// File: rtl/scc_cmd_pkg.sv
package scc_cmd_pkg;

  localparam int CMD_W = 8;

  localparam int CMD_RX_RELEASE = 7;
  localparam int CMD_RX_RESET   = 6;
  localparam int CMD_RNR_REPEAT = 5;
  localparam int CMD_TIMER      = 4;
  localparam int CMD_TX_TRANSP  = 3;
  localparam int CMD_MSG_END    = 1;
  localparam int CMD_TX_RESET   = 0;

  localparam logic [CMD_W-1:0] REPEAT_MASK =
    CMD_W'((1 << CMD_RNR_REPEAT) | (1 << CMD_TX_TRANSP) | (1 << CMD_MSG_END));

  typedef enum logic [1:0] {
    MODE_AUTO    = 2'b00,
    MODE_NONAUTO = 2'b01,
    MODE_XTRANS0 = 2'b10,
    MODE_XTRANS1 = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic rx_release;
    logic rx_reset;
    logic seq_clear;
    logic timer_start;
    logic tx_reset;
    logic repeat_start;
  } cmd_pulses_t;

endpackage

// File: rtl/scc_cmd_decode.sv
module scc_cmd_decode
  import scc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  op_mode_e         mode,
  input  logic             fifo_nonempty,
  input  logic             repeat_active,
  output cmd_pulses_t      pulses_o,
  output logic             rnr_o
);

  cmd_pulses_t pulses_d, pulses_q;
  logic        rnr_q;
  logic        is_auto, is_xtrans, repeat_pattern;

  assign is_auto        = (mode == MODE_AUTO);
  assign is_xtrans      = (mode == MODE_XTRANS0) || (mode == MODE_XTRANS1);
  assign repeat_pattern = ((cmd_wdata & REPEAT_MASK) == REPEAT_MASK) &&
                          !cmd_wdata[CMD_TX_RESET];

  always_comb begin
    pulses_d = '0;
    if (cmd_we) begin
      pulses_d.rx_release   = cmd_wdata[CMD_RX_RELEASE];
      pulses_d.rx_reset     = cmd_wdata[CMD_RX_RESET];
      pulses_d.seq_clear    = cmd_wdata[CMD_RX_RESET] && is_auto;
      pulses_d.timer_start  = cmd_wdata[CMD_TIMER];
      pulses_d.tx_reset     = cmd_wdata[CMD_TX_RESET];
      pulses_d.repeat_start = repeat_pattern && is_xtrans &&
                              fifo_nonempty && !repeat_active;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulses_q <= '0;
      rnr_q    <= 1'b0;
    end else begin
      pulses_q <= pulses_d;
      if (cmd_we && is_auto) rnr_q <= cmd_wdata[CMD_RNR_REPEAT];
    end
  end

  assign pulses_o = pulses_q;
  assign rnr_o    = rnr_q;

  AST_TIMER_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q.timer_start |-> $past(cmd_we && cmd_wdata[CMD_TIMER])); // R1
  AST_SEQ_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q.seq_clear |-> ($past(mode) == MODE_AUTO) && pulses_q.rx_reset); // R2
  AST_RNR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_we && (mode == MODE_AUTO)) |-> $stable(rnr_q)); // R3

endmodule

// File: rtl/scc_tx_fifo.sv
module scc_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             lock,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  input  logic [PW-1:0]    peek_off,
  output logic [WIDTH-1:0] peek_data,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr, peek_ptr;
  logic [CW-1:0]    cnt_q;
  logic             push, pop;

  assign in_ready  = !lock && (cnt_q < CW'(DEPTH));
  assign out_valid = !lock && (cnt_q != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];
  assign peek_ptr  = rd_ptr + peek_off;
  assign peek_data = mem[peek_ptr];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R4
  AST_LOCKED_STREAMS: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !in_ready && !out_valid); // R12
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !clear) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/scc_tx_serial.sv
module scc_tx_serial #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             bit_en,
  input  logic [CW-1:0]    count,
  input  logic [WIDTH-1:0] byte_data,
  output logic [PW-1:0]    byte_off,
  output logic             active,
  output logic             sdo
);

  logic          active_q;
  logic [PW-1:0] byte_idx;
  logic [BW-1:0] bit_idx;
  logic          last_bit, last_byte;

  assign last_bit  = (bit_idx == BW'(WIDTH - 1));
  assign last_byte = (({1'b0, byte_idx} + CW'(1)) == count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
    end else if (stop) begin
      active_q <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
    end else if (!active_q) begin
      if (start && (count != '0)) begin
        active_q <= 1'b1;
        byte_idx <= '0;
        bit_idx  <= '0;
      end
    end else if (bit_en) begin
      if (last_bit) begin
        bit_idx  <= '0;
        byte_idx <= last_byte ? '0 : byte_idx + PW'(1);
      end else begin
        bit_idx <= bit_idx + BW'(1);
      end
    end
  end

  assign byte_off = byte_idx;
  assign active   = active_q;
  assign sdo      = active_q ? byte_data[bit_idx] : 1'b1;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> sdo); // R11
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !bit_en && !stop) |=> $stable(sdo)); // R8
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active_q); // R9

endmodule

// File: rtl/scc_cmd_unit.sv
module scc_cmd_unit
  import scc_cmd_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_wdata,
  input  logic [1:0]       mode,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [WIDTH-1:0] ld_data,
  output logic             dr_valid,
  input  logic             dr_ready,
  output logic [WIDTH-1:0] dr_data,
  input  logic             bit_en,
  output logic             sdo,
  output logic             repeat_active,
  output logic             rnr_status,
  output logic             rx_release,
  output logic             rx_reset,
  output logic             seq_clear,
  output logic             timer_start,
  output logic             tx_reset
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  cmd_pulses_t      pulses;
  op_mode_e         mode_e;
  logic [CW-1:0]    fifo_count;
  logic [PW-1:0]    peek_off;
  logic [WIDTH-1:0] peek_data;
  logic             active;

  assign mode_e = op_mode_e'(mode);

  scc_cmd_decode u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_we        (cmd_we),
    .cmd_wdata     (cmd_wdata),
    .mode          (mode_e),
    .fifo_nonempty (fifo_count != '0),
    .repeat_active (active),
    .pulses_o      (pulses),
    .rnr_o         (rnr_status)
  );

  scc_tx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pulses.tx_reset),
    .lock      (active),
    .in_valid  (ld_valid),
    .in_ready  (ld_ready),
    .in_data   (ld_data),
    .out_valid (dr_valid),
    .out_ready (dr_ready),
    .out_data  (dr_data),
    .peek_off  (peek_off),
    .peek_data (peek_data),
    .count     (fifo_count)
  );

  scc_tx_serial #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pulses.repeat_start),
    .stop      (pulses.tx_reset),
    .bit_en    (bit_en),
    .count     (fifo_count),
    .byte_data (peek_data),
    .byte_off  (peek_off),
    .active    (active),
    .sdo       (sdo)
  );

  assign repeat_active = active;
  assign rx_release    = pulses.rx_release;
  assign rx_reset      = pulses.rx_reset;
  assign seq_clear     = pulses.seq_clear;
  assign timer_start   = pulses.timer_start;
  assign tx_reset      = pulses.tx_reset;

  AST_START_NEEDS_XT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(repeat_active) |-> ($past(mode, 2) != 2'b00) && ($past(mode, 2) != 2'b01)); // R10
  AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(repeat_active) |-> $past(cmd_we, 2) && ($past(cmd_wdata, 2) & 8'h2B) == 8'h2A); // R6
  AST_XRES_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> !repeat_active && sdo && !dr_valid); // R9

endmodule

// File: tb/tb_scc_cmd_unit.sv
module tb_scc_cmd_unit;

  localparam int DEPTH = 32;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_we = 1'b0;
  logic [7:0]       cmd_wdata = '0;
  logic [1:0]       mode = 2'b00;
  logic             ld_valid = 1'b0;
  logic             ld_ready;
  logic [WIDTH-1:0] ld_data = '0;
  logic             dr_valid;
  logic             dr_ready = 1'b0;
  logic [WIDTH-1:0] dr_data;
  logic             bit_en = 1'b0;
  logic             sdo, repeat_active, rnr_status;
  logic             rx_release, rx_reset, seq_clear, timer_start, tx_reset;

  int errs = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit exp_q[$];
  logic [7:0] blk [DEPTH];
  int blk_n = 0;

  always #2 clk = ~clk;

  scc_cmd_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .mode(mode),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_data(dr_data),
    .bit_en(bit_en), .sdo(sdo), .repeat_active(repeat_active), .rnr_status(rnr_status),
    .rx_release(rx_release), .rx_reset(rx_reset), .seq_clear(seq_clear),
    .timer_start(timer_start), .tx_reset(tx_reset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = d;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); ld_valid = 1'b1; ld_data = b;
    chk("R4 load ready", {31'b0, ld_ready}, 32'd1);
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic push_reps(input int reps);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < blk_n; i++)
        for (int k = 0; k < 8; k++) exp_q.push_back(blk[i][k]);
  endtask

  task automatic wait_drain();
    int g = 0;
    while (exp_q.size() > 0 && g < 4000) begin @(negedge clk); g++; end
    @(negedge clk);
    chk("R7 all bits seen", exp_q.size(), 32'd0);
  endtask

  // Scoreboard monitor: one new bit per negedge while bit_en stays high.
  always @(negedge clk) begin
    if (mon_en && repeat_active && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk("R7 serial bit", {31'b0, sdo}, {31'b0, e});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 sdo idle", {31'b0, sdo}, 32'd1);
    chk("R11 rnr", {31'b0, rnr_status}, 32'd0);
    chk("R11 pulses", {27'b0, rx_release, rx_reset, seq_clear, timer_start, tx_reset}, 32'd0);
    chk("R11 empty", {31'b0, dr_valid}, 32'd0);
    chk("R11 idle", {31'b0, repeat_active}, 32'd0);

    // R1 single pulses
    mode = 2'b00;
    wr(8'h80);
    chk("R1 release", {28'b0, rx_release, rx_reset, timer_start, tx_reset}, 32'h8);
    @(negedge clk);
    chk("R1 one cycle", {31'b0, rx_release}, 32'd0);
    wr(8'h10);
    chk("R1 timer", {28'b0, rx_release, rx_reset, timer_start, tx_reset}, 32'h2);
    // R2 sequence clear depends on mode
    wr(8'h40);
    chk("R2 auto reset", {30'b0, rx_reset, seq_clear}, 32'h3);
    mode = 2'b10;
    wr(8'h40);
    chk("R2 xt reset", {30'b0, rx_reset, seq_clear}, 32'h2);

    // R3 ready/not-ready status
    mode = 2'b00;
    wr(8'h20);
    chk("R3 rnr set", {31'b0, rnr_status}, 32'd1);
    mode = 2'b10;
    wr(8'h00);
    chk("R3 rnr kept", {31'b0, rnr_status}, 32'd1);
    mode = 2'b00;
    wr(8'h10);
    chk("R3 rnr clear", {31'b0, rnr_status}, 32'd0);

    // R5 drain order
    load(8'hA1); load(8'hB2); load(8'hC3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 valid", {31'b0, dr_valid}, 32'd1);
      chk("R5 order", {24'b0, dr_data}, (i == 0) ? 32'hA1 : (i == 1) ? 32'hB2 : 32'hC3);
      dr_ready = 1'b1;
      @(negedge clk); dr_ready = 1'b0;
    end
    chk("R5 empty", {31'b0, dr_valid}, 32'd0);

    // R10 auto mode combined write
    load(8'h96); load(8'h3C);
    mode = 2'b00;
    wr(8'h2A);
    repeat (3) @(negedge clk);
    chk("R10 no replay", {31'b0, repeat_active}, 32'd0);
    chk("R10 rnr", {31'b0, rnr_status}, 32'd1);
    chk("R10 unlocked", {31'b0, ld_ready}, 32'd1);

    // R6/R7 replay from a queue with an offset read pointer
    mode = 2'b11;
    blk[0] = 8'h96; blk[1] = 8'h3C; blk_n = 2;
    push_reps(3);
    bit_en = 1'b1; mon_en = 1'b1;
    wr(8'h2A);
    chk("R6 not yet", {31'b0, repeat_active}, 32'd0);
    @(negedge clk);
    chk("R6 started", {31'b0, repeat_active}, 32'd1);
    chk("R12 load locked", {31'b0, ld_ready}, 32'd0);
    chk("R12 drain locked", {31'b0, dr_valid}, 32'd0);
    // R8 stall mid-stream
    while (exp_q.size() > 21) @(negedge clk);
    @(posedge clk); #1 bit_en = 1'b0;
    @(posedge clk); #1 mon_en = 1'b0;
    hold = sdo;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R8 hold", {31'b0, sdo}, {31'b0, hold});
    end
    bit_en = 1'b1;
    @(posedge clk); #1 mon_en = 1'b1;
    wait_drain();
    // R12 repeat command while running is ignored
    wr(8'h2A);
    chk("R12 still locked", {31'b0, ld_ready}, 32'd0);

    // R9 stop
    mon_en = 1'b0;
    wr(8'h01);
    chk("R9 pulse", {31'b0, tx_reset}, 32'd1);
    @(negedge clk);
    chk("R9 stopped", {31'b0, repeat_active}, 32'd0);
    chk("R9 idle high", {31'b0, sdo}, 32'd1);
    chk("R9 emptied", {31'b0, dr_valid}, 32'd0);

    // R9 priority: 0x2B
    load(8'h55);
    mode = 2'b10;
    wr(8'h2B);
    repeat (3) @(negedge clk);
    chk("R9 priority", {30'b0, repeat_active, dr_valid}, 32'd0);

    // R6 empty queue and non-auto mode
    wr(8'h2A);
    repeat (3) @(negedge clk);
    chk("R6 empty no start", {31'b0, repeat_active}, 32'd0);
    load(8'h77);
    mode = 2'b01;
    wr(8'h2A);
    repeat (3) @(negedge clk);
    chk("R6 nonauto no start", {31'b0, repeat_active}, 32'd0);
    dr_ready = 1'b1; @(negedge clk); dr_ready = 1'b0;

    // R4 full queue, then R7 wrap across the storage end
    for (int i = 0; i < DEPTH; i++) begin
      blk[i] = 8'(i * 37 + 5);
      load(blk[i]);
    end
    blk_n = DEPTH;
    @(negedge clk);
    chk("R4 full", {31'b0, ld_ready}, 32'd0);
    mode = 2'b10;
    push_reps(1);
    for (int k = 0; k < 8; k++) exp_q.push_back(blk[0][k]);
    mon_en = 1'b1;
    wr(8'h2A);
    wait_drain();
    mon_en = 1'b0;
    wr(8'h01);
    @(negedge clk);
    chk("R9 final stop", {30'b0, repeat_active, sdo}, 32'd1);
    chk("R4 ready again", {31'b0, ld_ready}, 32'd1);
    finish_run();
  end

endmodule